// File: doc/BRIEF.md
# Branch Target Buffer with Return Stack

This block predicts branch targets for a simple in-order fetch stage. It keeps a small fully associative table of recently taken branches. Each entry holds the branch's word address, its last target, whether it jumps backward, and whether it is a plain branch, a subroutine call or a subroutine return. The fetch stage presents its current word address every cycle. In the same cycle it receives a hit flag and a predicted target.

The execute stage reports each resolved branch with its address, target, taken flag, direction and kind. The buffer uses these reports to allocate, refresh or drop entries. A four-deep return-address stack records the address after each resolved call. Entries of return kind take their prediction from the top of that stack rather than from their stored target.

Software drives the block through one 32-bit control register on a single-cycle register port. The register holds a global enable, a self-clearing flush command, and two direction filters: one limits which entries may produce a hit, the other limits which taken branches may claim a new entry.

Top module: `btb_top`

## Requirements
- R1: After reset the control register reads 0x00000000: the buffer is disabled and both filters are 00. While reset is held, fetchHit is low.
- R2: While the enable bit (bit 0) is 0, fetchHit stays low. Resolved branches then allocate no entry, change no entry and leave the return stack untouched.
- R3: Writing 1 to bit 1 starts a flush. Bit 1 reads 1 for the single cycle after the write and 0 from then on. When the flush completes, every entry is invalid, the return stack is empty and the round-robin pointer is back at entry 0.
- R4: While enabled, a resolved taken branch that matches no entry is written into an entry, subject to R7. Any later fetch of that address hits in the same cycle, and the stored target is returned. Any entry may hold any address.
- R5: Bits 3:2 filter hits by the direction stored in the entry: 00 lets both directions hit, 01 only backward, 10 only forward, 11 none.
- R6: A resolved taken branch that already has an entry overwrites that entry's target, direction and kind in place. The allocation filter does not apply to this. A resolved not-taken branch that has an entry invalidates it.
- R7: Bits 5:4 use the same encoding as bits 3:2. They decide whether a taken branch that missed may be allocated, based on its reported direction (exBackward = 1 means backward).
- R8: New entries go into the slot named by a round-robin pointer, which advances by one after each allocation and wraps at 8. Nine distinct allocations after a flush therefore evict the first one.
- R9: Kind codes are 00 plain, 01 call, 10 return. A resolved taken call pushes its address plus 1. A resolved taken return pops one stack entry. A hit on a return-kind entry predicts the current top of the stack.
- R10: The return stack holds 4 entries. A push onto a full stack overwrites the oldest entry. A fetch that matches a return-kind entry while the stack is empty reports a miss.
- R11: Bits 31:6 of the control register always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 32 | Control register write data |
| regRdData | output | 32 | Control register read data |
| fetchAddr | input | 30 | Current fetch word address |
| fetchHit | output | 1 | Prediction valid for fetchAddr |
| fetchTarget | output | 30 | Predicted target word address |
| exValid | input | 1 | A resolved branch is reported this cycle |
| exAddr | input | 30 | Word address of the resolved branch |
| exTarget | input | 30 | Resolved target word address |
| exTaken | input | 1 | Branch was taken |
| exBackward | input | 1 | 1 when the target is not above the branch address |
| exKind | input | 2 | 00 plain, 01 call, 10 return |

## Verification
Faults in the lookup side show up in the same cycle, because the hit flag and the target are purely combinational from the stored state. A lost or misplaced valid bit shows up on the first fetch of that address after the resolving edge. A wrong victim pointer stays hidden until the eviction that follows eight allocations. So the replacement scenario fills the table past capacity and probes every address. Errors in the stack pointer appear only on the first return prediction after a push or pop. The stack scenario therefore probes the top of stack after every single push and pop, through overflow and into the empty case.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'b00,
    KIND_CALL   = 2'b01,
    KIND_RETURN = 2'b10
  } brKind_e;

  typedef struct packed {
    logic       flush;
    logic       enable;
    logic [1:0] predFilter;
    logic [1:0] allocFilter;
  } ctrlStrobes_t;

  // 00 both, 01 backward only, 10 forward only, 11 none
  function automatic logic dirAllowed(input logic [1:0] filt, input logic backward);
    return (filt == 2'b00) || (filt == 2'b01 && backward) || (filt == 2'b10 && !backward);
  endfunction

endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [31:0]  regWrData,
  output logic [31:0]  regRdData,
  output ctrlStrobes_t strobes
);
  logic       enableQ;
  logic       flushPendQ;
  logic [1:0] predQ;
  logic [1:0] allocQ;
  logic       unusedWrBits;

  assign unusedWrBits = ^regWrData[31:6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ    <= 1'b0;
      flushPendQ <= 1'b0;
      predQ      <= 2'b00;
      allocQ     <= 2'b00;
    end else if (regWrEn) begin
      enableQ    <= regWrData[0];
      flushPendQ <= regWrData[1];
      predQ      <= regWrData[3:2];
      allocQ     <= regWrData[5:4];
    end else begin
      flushPendQ <= 1'b0;
    end
  end

  assign regRdData           = {26'b0, allocQ, predQ, flushPendQ, enableQ};
  assign strobes.flush       = flushPendQ;
  assign strobes.enable      = enableQ;
  assign strobes.predFilter  = predQ;
  assign strobes.allocFilter = allocQ;
endmodule

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 30,
  parameter int RAS_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchHit,
  output logic [ADDR_W-1:0] fetchTarget,
  input  logic              exValid,
  input  logic [ADDR_W-1:0] exAddr,
  input  logic [ADDR_W-1:0] exTarget,
  input  logic              exTaken,
  input  logic              exBackward,
  input  logic [1:0]        exKind
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int RP_W  = (RAS_DEPTH > 1) ? $clog2(RAS_DEPTH) : 1;
  localparam int CNT_W = $clog2(RAS_DEPTH + 1);
  localparam logic [CNT_W-1:0] RAS_FULL = CNT_W'(RAS_DEPTH);

  logic [NUM_ENTRIES-1:0] validQ;
  logic [ADDR_W-1:0]      tagQ  [NUM_ENTRIES];
  logic [ADDR_W-1:0]      tgtQ  [NUM_ENTRIES];
  logic                   bwdQ  [NUM_ENTRIES];
  logic [1:0]             kindQ [NUM_ENTRIES];
  logic [IDX_W-1:0]       victimQ;

  logic [ADDR_W-1:0] rasMem [RAS_DEPTH];
  logic [RP_W-1:0]   rasPtrQ;
  logic [CNT_W-1:0]  rasCountQ;
  logic              rasEmpty;

  logic [NUM_ENTRIES-1:0] fetchMatch, exMatch;
  logic [IDX_W-1:0]       fetchIdx, exIdx;
  logic                   exHit;

  generate
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
      assign fetchMatch[i] = validQ[i] && (tagQ[i] == fetchAddr);
      assign exMatch[i]    = validQ[i] && (tagQ[i] == exAddr);
    end
  endgenerate

  always_comb begin
    fetchIdx = '0;
    exIdx    = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (fetchMatch[i]) fetchIdx = IDX_W'(i);
      if (exMatch[i])    exIdx    = IDX_W'(i);
    end
  end

  assign exHit    = |exMatch;
  assign rasEmpty = (rasCountQ == '0);

  always_comb begin
    fetchHit    = 1'b0;
    fetchTarget = tgtQ[fetchIdx];
    if (strobes.enable && |fetchMatch && dirAllowed(strobes.predFilter, bwdQ[fetchIdx])) begin
      if (kindQ[fetchIdx] == KIND_RETURN) begin
        fetchHit    = !rasEmpty;
        fetchTarget = rasMem[rasPtrQ];
      end else begin
        fetchHit = 1'b1;
      end
    end
  end

  logic doUpdate, doInval, doAlloc, doPush, doPop;
  logic [IDX_W-1:0] wrIdx;

  always_comb begin
    logic active;
    active   = strobes.enable && exValid && !strobes.flush;
    doUpdate = active && exHit && exTaken;
    doInval  = active && exHit && !exTaken;
    doAlloc  = active && !exHit && exTaken && dirAllowed(strobes.allocFilter, exBackward);
    doPush   = active && exTaken && (exKind == KIND_CALL);
    doPop    = active && exTaken && (exKind == KIND_RETURN) && !rasEmpty;
    wrIdx    = exHit ? exIdx : victimQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ    <= '0;
      victimQ   <= '0;
      rasPtrQ   <= '0;
      rasCountQ <= '0;
    end else if (strobes.flush) begin
      validQ    <= '0;
      victimQ   <= '0;
      rasCountQ <= '0;
    end else begin
      if (doInval) validQ[exIdx] <= 1'b0;
      if (doAlloc) begin
        validQ[victimQ] <= 1'b1;
        victimQ <= (victimQ == IDX_W'(NUM_ENTRIES - 1)) ? '0 : victimQ + 1'b1;
      end
      if (doPush) begin
        rasPtrQ   <= (rasPtrQ == RP_W'(RAS_DEPTH - 1)) ? '0 : rasPtrQ + 1'b1;
        rasCountQ <= (rasCountQ == RAS_FULL) ? rasCountQ : rasCountQ + 1'b1;
      end else if (doPop) begin
        rasPtrQ   <= (rasPtrQ == '0) ? RP_W'(RAS_DEPTH - 1) : rasPtrQ - 1'b1;
        rasCountQ <= rasCountQ - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doUpdate || doAlloc) begin
      tagQ[wrIdx]  <= exAddr;
      tgtQ[wrIdx]  <= exTarget;
      bwdQ[wrIdx]  <= exBackward;
      kindQ[wrIdx] <= exKind;
    end
    if (doPush && !strobes.flush) begin
      rasMem[(rasPtrQ == RP_W'(RAS_DEPTH - 1)) ? '0 : rasPtrQ + 1'b1] <= exAddr + 1'b1;
    end
  end
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [29:0] fetchAddr,
  output logic        fetchHit,
  output logic [29:0] fetchTarget,
  input  logic        exValid,
  input  logic [29:0] exAddr,
  input  logic [29:0] exTarget,
  input  logic        exTaken,
  input  logic        exBackward,
  input  logic [1:0]  exKind
);
  ctrlStrobes_t strobes;

  btb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .strobes(strobes)
  );

  btb_datapath #(.NUM_ENTRIES(8), .ADDR_W(30), .RAS_DEPTH(4)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .fetchAddr(fetchAddr), .fetchHit(fetchHit), .fetchTarget(fetchTarget),
    .exValid(exValid), .exAddr(exAddr), .exTarget(exTarget),
    .exTaken(exTaken), .exBackward(exBackward), .exKind(exKind)
  );
endmodule

// File: rtl/btb_checker.sv
module btb_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] regRdData,
  input logic        fetchHit
);
  // R1: a register held in reset reads zero on the following cycle
  a_r1_reset_value: assert property (@(posedge clk) !rstN |=> (regRdData == 32'h0));

  // R2: no prediction while disabled
  a_r2_no_hit_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[0] |-> !fetchHit);

  // R3: flush bit is visible for one cycle only
  a_r3_flush_selfclear: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[1] |=> !regRdData[1]);

  // R3: after a flush no entry can hit
  a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[1] |=> !fetchHit);

  // R5: filter code 11 blocks every prediction
  a_r5_pred_none: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[3:2] == 2'b11) |-> !fetchHit);

  // R11: reserved bits read zero
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[31:6] == 26'h0);
endmodule

bind btb_top btb_checker u_chk (
  .clk(clk), .rstN(rstN), .regRdData(regRdData), .fetchHit(fetchHit)
);

// File: tb/tb_btb_top.sv
module tb_btb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [29:0] fetchAddr = '0;
  logic        fetchHit;
  logic [29:0] fetchTarget;
  logic        exValid = 1'b0;
  logic [29:0] exAddr = '0;
  logic [29:0] exTarget = '0;
  logic        exTaken = 1'b0;
  logic        exBackward = 1'b0;
  logic [1:0]  exKind = 2'b00;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  btb_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [31:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic flushWith(input logic [31:0] v);
    wrCtrl(v | 32'h2);
    @(negedge clk);
  endtask

  task automatic resolve(input logic [29:0] a, input logic [29:0] t, input logic tk,
                         input logic bwd, input logic [1:0] k);
    @(negedge clk);
    exValid = 1'b1; exAddr = a; exTarget = t; exTaken = tk; exBackward = bwd; exKind = k;
    @(negedge clk);
    exValid = 1'b0;
  endtask

  task automatic look(input string req, input logic [29:0] a, input logic expHit,
                      input logic [29:0] expTgt);
    fetchAddr = a;
    #1;
    chk(req, {31'b0, fetchHit}, {31'b0, expHit});
    if (expHit) chk(req, {2'b0, fetchTarget}, {2'b0, expTgt});
  endtask

  task automatic testReset();
    chk("R1 reset reg", regRdData, 32'h0);
    look("R1 reset hit", 30'h100, 1'b0, '0);
  endtask

  task automatic testDisabled();
    resolve(30'h100, 30'h200, 1'b1, 1'b0, 2'b00);
    look("R2 disabled lookup", 30'h100, 1'b0, '0);
    wrCtrl(32'h1);
    look("R2 no alloc while disabled", 30'h100, 1'b0, '0);
  endtask

  task automatic testFlushReg();
    wrCtrl(32'hFFFF_FFFF);
    chk("R3 R11 flush visible", regRdData, 32'h3F);
    @(negedge clk);
    chk("R3 R11 flush cleared", regRdData, 32'h3D);
    flushWith(32'h1);
    chk("R3 enabled reg", regRdData, 32'h1);
  endtask

  task automatic testAllocUpdate();
    resolve(30'h100, 30'h200, 1'b1, 1'b0, 2'b00);
    look("R4 alloc hit", 30'h100, 1'b1, 30'h200);
    look("R4 other miss", 30'h104, 1'b0, '0);
    resolve(30'h100, 30'h300, 1'b1, 1'b0, 2'b00);
    look("R6 update in place", 30'h100, 1'b1, 30'h300);
    resolve(30'h100, 30'h300, 1'b0, 1'b0, 2'b00);
    look("R6 not-taken invalidates", 30'h100, 1'b0, '0);
  endtask

  task automatic testPredFilter();
    resolve(30'h100, 30'h200, 1'b1, 1'b0, 2'b00);
    resolve(30'h400, 30'h380, 1'b1, 1'b1, 2'b00);
    wrCtrl(32'h9);
    look("R5 fwd-only fwd", 30'h100, 1'b1, 30'h200);
    look("R5 fwd-only bwd", 30'h400, 1'b0, '0);
    wrCtrl(32'h5);
    look("R5 bwd-only fwd", 30'h100, 1'b0, '0);
    look("R5 bwd-only bwd", 30'h400, 1'b1, 30'h380);
    wrCtrl(32'hD);
    look("R5 none fwd", 30'h100, 1'b0, '0);
    look("R5 none bwd", 30'h400, 1'b0, '0);
    wrCtrl(32'h1);
    look("R5 both restored", 30'h400, 1'b1, 30'h380);
  endtask

  task automatic testAllocFilter();
    flushWith(32'h11);
    resolve(30'h500, 30'h600, 1'b1, 1'b0, 2'b00);
    resolve(30'h700, 30'h6F0, 1'b1, 1'b1, 2'b00);
    look("R7 fwd filtered out", 30'h500, 1'b0, '0);
    look("R7 bwd allocated", 30'h700, 1'b1, 30'h6F0);
    wrCtrl(32'h21);
    resolve(30'h700, 30'h6E0, 1'b1, 1'b1, 2'b00);
    look("R6 update ignores alloc filter", 30'h700, 1'b1, 30'h6E0);
    resolve(30'h500, 30'h600, 1'b1, 1'b0, 2'b00);
    look("R7 fwd-only fwd allocated", 30'h500, 1'b1, 30'h600);
  endtask

  task automatic testReplace();
    flushWith(32'h1);
    look("R3 flush invalidates", 30'h700, 1'b0, '0);
    for (int i = 0; i < 9; i++)
      resolve(30'h1000 + 30'(i), 30'h2000 + 30'(i), 1'b1, 1'b0, 2'b00);
    look("R8 first evicted", 30'h1000, 1'b0, '0);
    for (int i = 1; i < 9; i++)
      look("R8 survivor", 30'h1000 + 30'(i), 1'b1, 30'h2000 + 30'(i));
  endtask

  task automatic testStack();
    flushWith(32'h1);
    resolve(30'h900, 30'h123, 1'b1, 1'b0, 2'b10);
    look("R10 empty stack miss", 30'h900, 1'b0, '0);
    resolve(30'h500, 30'h800, 1'b1, 1'b0, 2'b01);
    look("R9 call entry target", 30'h500, 1'b1, 30'h800);
    look("R9 return predicts top", 30'h900, 1'b1, 30'h501);
    resolve(30'h900, 30'h501, 1'b1, 1'b0, 2'b10);
    look("R9 pop empties", 30'h900, 1'b0, '0);
    for (int i = 1; i <= 5; i++) begin
      resolve(30'h10 * 30'(i), 30'h3000, 1'b1, 1'b0, 2'b01);
      look("R9 push top", 30'h900, 1'b1, 30'h10 * 30'(i) + 30'h1);
    end
    resolve(30'h900, 30'h51, 1'b1, 1'b0, 2'b10);
    look("R10 pop 1", 30'h900, 1'b1, 30'h41);
    resolve(30'h900, 30'h41, 1'b1, 1'b0, 2'b10);
    look("R10 pop 2", 30'h900, 1'b1, 30'h31);
    resolve(30'h900, 30'h31, 1'b1, 1'b0, 2'b10);
    look("R10 pop 3", 30'h900, 1'b1, 30'h21);
    resolve(30'h900, 30'h21, 1'b1, 1'b0, 2'b10);
    look("R10 oldest overwritten", 30'h900, 1'b0, '0);
  endtask

  task automatic testStackFlush();
    resolve(30'h500, 30'h800, 1'b1, 1'b0, 2'b01);
    look("R9 push before flush", 30'h900, 1'b1, 30'h501);
    wrCtrl(32'h0);
    resolve(30'h60, 30'h800, 1'b1, 1'b0, 2'b01);
    wrCtrl(32'h1);
    look("R2 no push while disabled", 30'h900, 1'b1, 30'h501);
    flushWith(32'h1);
    resolve(30'h900, 30'h1, 1'b1, 1'b0, 2'b10);
    look("R3 stack emptied", 30'h900, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testFlushReg();
    testAllocUpdate();
    testPredFilter();
    testAllocFilter();
    testReplace();
    testStack();
    testStackFlush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule